// File: doc/BRIEF.md
# Double-Buffered Full-Duplex Serial Port (Master/Slave)

This block is a synchronous serial port that moves characters in both directions at the same time. The host side is parallel. The host writes a transmit word, reads a receive word, watches three flags and programs a mode word. The serial side has a clock, a data-out line, a data-in line and an active-low select input. One shift register serves both directions. The same clock edge that moves a bit out also brings a bit in. A holding register sits on each side of the shift register, so each direction can have two characters in flight.

As bus master the block divides its system clock to make the serial clock. A character starts only when the host has loaded transmit data. As slave it follows an external serial clock while select is low. Both roles use clock-idle-low timing: data changes after a falling edge and is sampled on a rising edge. The most significant bit goes first. The character length can be set at run time anywhere from 4 to 16 bits. If the host refills the transmit holding register before the current character ends, the next character follows with no gap.

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: After reset, tx_empty_o=1, rx_full_o=0, rx_ovr_o=0, sck_o=0 and sdo_o=0.
- R2: A pulse on cfg_we_i loads the mode word. Bit 0 is enable, bit 1 selects master (1) or slave (0), bits 5:2 hold the character length minus one, and bits 13:6 hold the divider N. A length field below 3 is treated as 3, which gives 4-bit characters.
- R3: In master mode, sck_o idles low and rises every 2×(N+1) system clocks while a character is moving. sdo_o changes only while sck_o is low. The transmit word goes out most significant bit first.
- R4: Each rising serial clock samples the data input, so every bit sent is paired with a bit received. The received character is right-justified in rx_data_o and its upper bits are zero.
- R5: Any character length from 4 to 16 bits is sent and received correctly. Only the low bits of tx_data_i are transmitted.
- R6: When transmit data is waiting at the end of a character, the next character follows with the sck_o period unchanged across the boundary.
- R7: A master transfer starts only when the transmit holding register holds data. tx_empty_o rises once that word has moved into the shift register.
- R8: A host write while the transmit holding register is full is ignored, and the held word is kept.
- R9: A completed character sets rx_full_o. An rx_re_i pulse clears rx_full_o and rx_ovr_o. If a character completes while rx_full_o=1, that newer character is discarded, rx_ovr_o is set and rx_data_o keeps the older word.
- R10: While enable is clear, sck_o does not toggle, no character moves and a written transmit word stays held.
- R11: In slave mode, bits are clocked by sck_i while sel_ni is low, and sck_o stays low. sdo_o sends the held transmit word most significant bit first, or zeros if none is held.
- R12: In slave mode, if sel_ni rises mid-character, that character is dropped and the bit count restarts, so the next selected character is received whole.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mode word write strobe |
| cfg_wdata_i | input | 14 | Mode word |
| tx_we_i | input | 1 | Transmit write strobe |
| tx_data_i | input | 16 | Transmit word |
| rx_re_i | input | 1 | Receive read strobe |
| rx_data_o | output | 16 | Received word, right-justified |
| tx_empty_o | output | 1 | Transmit holding register empty |
| rx_full_o | output | 1 | Receive holding register full |
| rx_ovr_o | output | 1 | Receive overrun |
| sck_o | output | 1 | Serial clock out (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| sel_ni | input | 1 | Slave select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
Some rules are checked on every cycle:
- sck_o stays low while the block is disabled or in slave mode.
- An overrun keeps the older receive word and raises the flag.
- A full transmit holding register is never overwritten.
- A transfer never takes a word from an empty holding register.
- Deselect aborts an active slave character.

Other behaviours show up only in the bench scenarios:
- Correct bit order and right-justification across lengths.
- Full-duplex pairing of sent and received words.
- The exact serial-clock period and the absence of a gap between streamed characters.
- Recovery of a whole character after a slave abort.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned LEN_W      = 4;
  localparam int unsigned DIV_W      = 8;
  localparam int unsigned CFG_W      = DIV_W + LEN_W + 2;
  localparam int unsigned MIN_LEN_M1 = 3;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [LEN_W-1:0] len_m1;
    logic             master;
    logic             en;
  } spi_mode_t;

  function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] lm);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i <= int'(lm));
    return m;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[0] <= RST_VAL;
        else         stg[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = run_i && wrap;

  // counter restarts from zero whenever the engine is idle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || wrap)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/spi_hold_regs.sv
module spi_hold_regs #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_take_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_word_o,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              rx_re_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              rx_ovr_o
);
  logic              tx_full_q;
  logic [DATA_W-1:0] tx_q;
  logic              rx_full_q, ovr_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      tx_full_q <= 1'b0;
      tx_q      <= '0;
    end else if (tx_take_i) begin
      tx_full_q <= 1'b0;
    end else if (tx_we_i && !tx_full_q) begin
      tx_full_q <= 1'b1;
      tx_q      <= tx_data_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
      rx_q      <= '0;
    end else if (rx_done_i) begin
      if (rx_full_q && !rx_re_i) begin
        ovr_q <= 1'b1;           // newest character dropped
      end else begin
        rx_q      <= rx_word_i;
        rx_full_q <= 1'b1;
        ovr_q     <= 1'b0;
      end
    end else if (rx_re_i) begin
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
    end

  assign tx_valid_o = tx_full_q;
  assign tx_word_o  = tx_q;
  assign rx_data_o  = rx_q;
  assign rx_full_o  = rx_full_q;
  assign rx_ovr_o   = ovr_q;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic              tick_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sel_act_i,
  input  logic              sdi_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              tx_take_o,
  output logic              rx_done_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              active_o,
  output logic              sck_o,
  output logic              sdo_o
);
  localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(DATA_W - 1);

  logic              active_q, sck_q, samp_q;
  logic [DATA_W-1:0] sh_q, sh_shift, ld_word, mask;
  logic [LEN_W-1:0]  cnt_q;
  logic              start, rise, fall, abort, last, reload;

  assign mask     = len_mask(len_m1_i);
  // left-justify so the character MSB sits at the output bit
  assign ld_word  = (tx_valid_i ? tx_word_i : '0) << (TOP_IDX - len_m1_i);
  assign sh_shift = {sh_q[DATA_W-2:0], samp_q};

  assign start  = en_i && !active_q && (master_i ? tx_valid_i : sel_act_i);
  assign rise   = active_q && (master_i ? (tick_i && !sck_q) : sck_rise_i);
  assign fall   = active_q && (master_i ? (tick_i &&  sck_q) : sck_fall_i);
  assign abort  = active_q && !master_i && !sel_act_i;
  assign last   = fall && (cnt_q == len_m1_i);
  assign reload = last && master_i && tx_valid_i;

  assign tx_take_o = (start && tx_valid_i) || (reload && !abort);
  assign rx_done_o = last && !abort;
  assign rx_word_o = sh_shift & mask;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      samp_q   <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (!master_i) sck_q <= 1'b0;
      if (abort) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (start) begin
        active_q <= 1'b1;
        sh_q     <= ld_word;
        cnt_q    <= '0;
        sck_q    <= 1'b0;
      end else begin
        if (rise) begin
          samp_q <= sdi_i;
          if (master_i) sck_q <= 1'b1;
        end
        if (fall) begin
          sck_q <= 1'b0;
          if (cnt_q == len_m1_i) begin
            cnt_q <= '0;
            if (reload) sh_q <= ld_word;
            else begin
              sh_q     <= sh_shift;
              active_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
            sh_q  <= sh_shift;
          end
        end
      end
    end

  assign active_o = active_q;
  assign sck_o    = sck_q;
  assign sdo_o    = active_q & sh_q[DATA_W-1];
endmodule

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl
  import spi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_re_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_empty_o,
  output logic              rx_full_o,
  output logic              rx_ovr_o,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              sel_ni,
  input  logic              sdi_i,
  output logic              sdo_o
);
  spi_mode_t         mode_q;
  logic [LEN_W-1:0]  len_eff;
  logic              sck_s, sel_s, sdi_s, sck_prev_q;
  logic              s_rise, s_fall, sel_act, sdi_mux;
  logic              tick, sh_active, tx_take, tx_valid, rx_done;
  logic [DATA_W-1:0] tx_word, rx_word;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       mode_q <= '0;
    else if (cfg_we_i) mode_q <= spi_mode_t'(cfg_wdata_i);

  assign len_eff = (mode_q.len_m1 < LEN_W'(MIN_LEN_M1)) ? LEN_W'(MIN_LEN_M1) : mode_q.len_m1;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, sel_ni, sdi_i}),
    .q_o   ({sck_s, sel_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_prev_q <= 1'b0;
    else         sck_prev_q <= sck_s;

  assign s_rise  =  sck_s && !sck_prev_q;
  assign s_fall  = !sck_s &&  sck_prev_q;
  assign sel_act = !sel_s;
  // master samples the line directly; slave uses the aligned synchronized copy
  assign sdi_mux = mode_q.master ? sdi_i : sdi_s;

  spi_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (sh_active && mode_q.master && mode_q.en),
    .div_i (mode_q.div),
    .tick_o(tick)
  );

  spi_shifter i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (mode_q.en),
    .master_i  (mode_q.master),
    .len_m1_i  (len_eff),
    .tick_i    (tick),
    .sck_rise_i(s_rise),
    .sck_fall_i(s_fall),
    .sel_act_i (sel_act),
    .sdi_i     (sdi_mux),
    .tx_valid_i(tx_valid),
    .tx_word_i (tx_word),
    .tx_take_o (tx_take),
    .rx_done_o (rx_done),
    .rx_word_o (rx_word),
    .active_o  (sh_active),
    .sck_o     (sck_o),
    .sdo_o     (sdo_o)
  );

  spi_hold_regs #(.DATA_W(DATA_W)) i_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_we_i   (tx_we_i),
    .tx_data_i (tx_data_i),
    .tx_take_i (tx_take),
    .tx_valid_o(tx_valid),
    .tx_word_o (tx_word),
    .rx_done_i (rx_done),
    .rx_word_i (rx_word),
    .rx_re_i   (rx_re_i),
    .rx_data_o (rx_data_o),
    .rx_full_o (rx_full_o),
    .rx_ovr_o  (rx_ovr_o)
  );

  assign tx_empty_o = !tx_valid;
endmodule

// File: rtl/spi_dbuf_ctrl_chk.sv
module spi_dbuf_ctrl_chk
  import spi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic              master,
  input logic              sck_o,
  input logic              tx_we_i,
  input logic              tx_valid,
  input logic              tx_take,
  input logic [DATA_W-1:0] tx_word,
  input logic              rx_done,
  input logic              rx_re_i,
  input logic              rx_full_o,
  input logic              rx_ovr_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              sh_active,
  input logic              sel_act
);
  p_quiet_when_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !sck_o);

  p_no_sck_out_slave_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master |=> !sck_o);

  p_overrun_keeps_old_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done && rx_full_o && !rx_re_i |=> rx_ovr_o && $stable(rx_data_o));

  p_done_fills_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done |=> rx_full_o);

  p_tx_no_overwrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid && tx_we_i && !tx_take |=> tx_valid && $stable(tx_word));

  p_take_has_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take |-> tx_valid);

  p_deselect_aborts_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_active && !master && !sel_act |=> !sh_active);
endmodule

bind spi_dbuf_ctrl spi_dbuf_ctrl_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en       (mode_q.en),
  .master   (mode_q.master),
  .sck_o    (sck_o),
  .tx_we_i  (tx_we_i),
  .tx_valid (tx_valid),
  .tx_take  (tx_take),
  .tx_word  (tx_word),
  .rx_done  (rx_done),
  .rx_re_i  (rx_re_i),
  .rx_full_o(rx_full_o),
  .rx_ovr_o (rx_ovr_o),
  .rx_data_o(rx_data_o),
  .sh_active(sh_active),
  .sel_act  (sel_act)
);

// File: tb/test_spi_dbuf_ctrl.sv
module test_spi_dbuf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, tx_we, rx_re;
  logic [13:0] cfg_wdata;
  logic [15:0] tx_data, rx_data;
  logic        tx_empty, rx_full, rx_ovr, sck_o, sdo;
  logic        sck_in, sel_n, sdi, m_sdi, s_sdi, mode_m;

  always #4 clk = ~clk;

  spi_dbuf_ctrl i_spi_dbuf_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .tx_we_i(tx_we), .tx_data_i(tx_data), .rx_re_i(rx_re), .rx_data_o(rx_data),
    .tx_empty_o(tx_empty), .rx_full_o(rx_full), .rx_ovr_o(rx_ovr),
    .sck_o(sck_o), .sck_i(sck_in), .sel_ni(sel_n), .sdi_i(sdi), .sdo_o(sdo)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(negedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lmask(input int l);
    return (l >= 16) ? 16'hFFFF : ((16'h1 << l) - 16'h1);
  endfunction

  // bench slave model for master-mode runs
  logic [15:0] mw [8];
  logic [15:0] sw [8];
  logic [15:0] capw [8];
  logic [15:0] rxw [8];
  logic [15:0] m_cap;
  int m_widx, m_bidx, m_len, last_rise, per_exp, per_bad, rise_cnt;

  always_comb m_sdi = (m_widx < 8) ? sw[m_widx][m_len-1-m_bidx] : 1'b0;
  assign sdi = mode_m ? m_sdi : s_sdi;

  always @(posedge sck_o) begin
    rise_cnt++;
    if (last_rise >= 0 && (cyc - last_rise) != per_exp) per_bad++;
    last_rise = cyc;
    m_cap = {m_cap[14:0], sdo};
    m_bidx++;
    if (m_bidx == m_len) begin
      if (m_widx < 8) capw[m_widx] = m_cap & lmask(m_len);
      m_widx++;
      m_bidx = 0;
    end
  end

  task automatic cfg(input bit en, input bit ms, input int lm, input int dv);
    @(negedge clk);
    cfg_wdata = {dv[7:0], lm[3:0], ms, en};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic host_write(input logic [15:0] d);
    @(negedge clk);
    tx_data = d; tx_we = 1'b1;
    @(negedge clk);
    tx_we = 1'b0;
  endtask

  task automatic host_read(output logic [15:0] d);
    @(negedge clk);
    d = rx_data; rx_re = 1'b1;
    @(negedge clk);
    rx_re = 1'b0;
  endtask

  task automatic model_init(input int len, input int dv);
    m_widx = 0; m_bidx = 0; m_len = len; m_cap = '0;
    last_rise = -1; per_exp = 2 * (dv + 1); per_bad = 0;
  endtask

  task automatic master_run(input int n, input int lm, input int dv);
    int len, sent, recv, guard;
    len = (lm < 3) ? 4 : lm + 1;
    for (int k = 0; k < n; k++) begin
      mw[k] = 16'($urandom);
      sw[k] = 16'($urandom);
    end
    mode_m = 1'b1;
    model_init(len, dv);
    cfg(1'b1, 1'b1, lm, dv);
    sent = 0; recv = 0; guard = 0;
    while (recv < n && guard < 20000) begin
      @(negedge clk);
      tx_we = 1'b0; rx_re = 1'b0; guard++;
      if (rx_full) begin rxw[recv] = rx_data; recv++; rx_re = 1'b1; end
      if (tx_empty && sent < n) begin tx_data = mw[sent]; sent++; tx_we = 1'b1; end
    end
    @(negedge clk);
    tx_we = 1'b0; rx_re = 1'b0;
    chk(recv == n, "R7 all characters completed", recv, n);
    for (int k = 0; k < n; k++) begin
      chk(rxw[k] == (sw[k] & lmask(len)), "R4/R5 received word right-justified", rxw[k], sw[k] & lmask(len));
      chk(capw[k] == (mw[k] & lmask(len)), "R3/R5 sent word msb first", capw[k], mw[k] & lmask(len));
    end
    chk(per_bad == 0, "R6/R3 sck period uniform across characters", per_bad, 0);
    chk(sck_o == 1'b0, "R3 sck idles low", sck_o, 0);
  endtask

  task automatic slave_char(input logic [15:0] w, input int len, input int nbits, output logic [15:0] cap);
    cap = '0;
    sel_n = 1'b0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      s_sdi = w[len-1-i];
      repeat (16) @(negedge clk);
      cap = {cap[14:0], sdo};
      sck_in = 1'b1;
      repeat (16) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (16) @(negedge clk);
    sel_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] rd, cap, a_w, t_w, m_w;
    int rc0, guard;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = '0; tx_we = 0; tx_data = '0; rx_re = 0;
    sck_in = 0; sel_n = 1; s_sdi = 0; mode_m = 1;
    rise_cnt = 0; model_init(8, 0);
    for (int k = 0; k < 8; k++) begin sw[k] = '0; mw[k] = '0; capw[k] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(tx_empty == 1'b1, "R1 tx_empty after reset", tx_empty, 1);
    chk(rx_full == 1'b0, "R1 rx_full after reset", rx_full, 0);
    chk(rx_ovr == 1'b0, "R1 rx_ovr after reset", rx_ovr, 0);
    chk(sck_o == 1'b0 && sdo == 1'b0, "R1 serial outputs low", {sck_o, sdo}, 0);

    // R7: enabled master with nothing to send stays quiet
    cfg(1'b1, 1'b1, 7, 0);
    rc0 = rise_cnt;
    repeat (50) @(negedge clk);
    chk(rise_cnt == rc0, "R7 no transfer without data", rise_cnt - rc0, 0);

    // directed length and divider corners
    master_run(3, 15, 0);
    master_run(3, 3, 2);
    master_run(2, 1, 0);    // R2 clamp: short field acts as 4 bits
    master_run(2, 0, 1);
    for (int r = 0; r < 4; r++) master_run(3, int'($urandom_range(3, 15)), int'($urandom_range(0, 5)));

    // R10 / R8: disabled block holds the word, a second write is dropped
    mode_m = 1'b1;
    cfg(1'b0, 1'b1, 7, 1);
    rc0 = rise_cnt;
    a_w = 16'h00A5;
    host_write(a_w);
    repeat (60) @(negedge clk);
    chk(rise_cnt == rc0, "R10 no sck while disabled", rise_cnt - rc0, 0);
    chk(tx_empty == 1'b0, "R10 tx word held while disabled", tx_empty, 0);
    host_write(16'h005A);
    sw[0] = 16'h00C3;
    model_init(8, 1);
    cfg(1'b1, 1'b1, 7, 1);
    guard = 0;
    while (!rx_full && guard < 2000) begin @(negedge clk); guard++; end
    host_read(rd);
    chk(capw[0] == a_w, "R8 held word sent, later write ignored", capw[0], a_w);
    chk(rd == 16'h00C3, "R4 received word", rd, 16'h00C3);
    repeat (200) @(negedge clk);
    chk(tx_empty == 1'b1 && rx_full == 1'b0, "R8 no second character", {tx_empty, rx_full}, 2'b10);

    // R9 overrun
    sw[0] = 16'($urandom); sw[1] = 16'($urandom);
    model_init(8, 1);
    host_write(16'h0011);
    guard = 0;
    while (!tx_empty && guard < 2000) begin @(negedge clk); guard++; end
    host_write(16'h0022);
    guard = 0;
    while (m_widx < 2 && guard < 4000) begin @(negedge clk); guard++; end
    repeat (10) @(negedge clk);
    chk(rx_full == 1'b1, "R9 rx_full set", rx_full, 1);
    chk(rx_ovr == 1'b1, "R9 overrun flagged", rx_ovr, 1);
    chk(rx_data == (sw[0] & 16'h00FF), "R9 older word kept", rx_data, sw[0] & 16'h00FF);
    host_read(rd);
    @(negedge clk);
    chk(rx_ovr == 1'b0 && rx_full == 1'b0, "R9 read clears flags", {rx_full, rx_ovr}, 0);

    // slave mode
    mode_m = 1'b0;
    cfg(1'b1, 1'b0, 7, 0);
    t_w = 16'($urandom); m_w = 16'($urandom);
    host_write(t_w);
    slave_char(m_w, 8, 8, cap);
    chk(cap == (t_w & 16'h00FF), "R11 slave sends held word msb first", cap, t_w & 16'h00FF);
    chk(rx_full == 1'b1, "R11 slave character received", rx_full, 1);
    chk(sck_o == 1'b0, "R11 sck_o low in slave", sck_o, 0);
    host_read(rd);
    chk(rd == (m_w & 16'h00FF), "R11 slave rx data", rd, m_w & 16'h00FF);

    m_w = 16'($urandom);
    slave_char(m_w, 8, 8, cap);
    chk(cap == 16'h0000, "R11 slave sends zeros when empty", cap, 0);
    host_read(rd);
    chk(rd == (m_w & 16'h00FF), "R11 slave rx with empty tx", rd, m_w & 16'h00FF);

    cfg(1'b1, 1'b0, 11, 0);
    t_w = 16'($urandom); m_w = 16'($urandom);
    host_write(t_w);
    slave_char(m_w, 12, 12, cap);
    chk(cap == (t_w & 16'h0FFF), "R11/R5 slave 12-bit send", cap, t_w & 16'h0FFF);
    host_read(rd);
    chk(rd == (m_w & 16'h0FFF), "R11/R5 slave 12-bit receive", rd, m_w & 16'h0FFF);

    // R12 abort
    cfg(1'b1, 1'b0, 7, 0);
    host_write(16'h00F0);
    slave_char(16'h00FF, 8, 3, cap);
    chk(rx_full == 1'b0, "R12 aborted character not received", rx_full, 0);
    t_w = 16'($urandom); m_w = 16'($urandom);
    host_write(t_w);
    slave_char(m_w, 8, 8, cap);
    chk(cap == (t_w & 16'h00FF), "R12 bit count restarts on send", cap, t_w & 16'h00FF);
    host_read(rd);
    chk(rd == (m_w & 16'h00FF), "R12 whole character after abort", rd, m_w & 16'h00FF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule